// File: doc/BRIEF.md
# Column Up/Down Counter with Digital Double Sampling

This block is the digital half of one column of a single-slope converter. The column first converts the reset level of the pixel and then its signal level. Each conversion is a counting phase that ends when the column comparator output rises. The counter works the two phases into one value, so the word left at the end is already the signal count minus the reset count. Any fixed offset or latency that both phases share cancels out of that difference.

Two subtraction methods can be selected. In the down-count method the counter runs downward during the reset phase and upward during the signal phase. This keeps the switching activity the same in both phases. In the invert method the counter runs upward in both phases. All bits are complemented at the start of the signal phase, which is a large simultaneous switching event, and a final +1 finishes the two's-complement negation.

A double-rate option doubles the time resolution. The counter then counts two steps for each clock cycle, and it adds one more step when the comparator flipped in the second half of the last cycle. A phase in which the comparator never flips saturates and raises an overflow flag. A one-cycle done pulse marks a new result, and that result is held until the next reset-phase start.

Top module: `col_dcds_counter`

## Requirements
- R1: With mode_i=0 (down-count), after a reset phase and a signal phase, result_o holds the signal phase count minus the reset phase count as a CNT_W-bit two's-complement value.
- R2: With mode_i=1 (invert), result_o holds the same difference as R1 for the same comparator timing.
- R3: With ddr_i=1, each counting cycle adds 2 to the phase count. The stop cycle adds 1 more if the comparator rose in the second half of a clock period, that is after the falling edge. With ddr_i=0 each counting cycle adds 1, and the position inside the period has no effect.
- R4: cmp_i passes through a two-flop synchronizer. Counting stops on its first synchronized high. A phase count equals the number of clock periods from start to the comparator rise plus a fixed latency of 2, and this latency cancels in the result.
- R5: A phase whose count reaches 2^(CNT_W-1)-1 stops there and sets ovf_o. ovf_o stays set until the next reset-phase start.
- R6: done_o is high for exactly one cycle per conversion, one cycle after the signal phase stops. result_o holds its value until the next reset-phase start, which clears result_o and ovf_o to 0.
- R7: mode_i and ddr_i are sampled at the reset-phase start, and later changes do not affect the running conversion.
- R8: After rst_ni is released, result_o=0, done_o=0 and ovf_o=0.
- R9: A pulse on start_i begins a phase. phase_i selects which one: 0 for the reset level, 1 for the signal level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Count clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmp_i | input | 1 | Column comparator output, asynchronous, rises to end a phase |
| start_i | input | 1 | One-cycle pulse that begins a phase |
| phase_i | input | 1 | Phase selected by start_i: 0 reset level, 1 signal level |
| mode_i | input | 1 | Subtraction method: 0 down-count, 1 invert |
| ddr_i | input | 1 | 1 selects double-rate counting |
| result_o | output | CNT_W | Signed difference, signal count minus reset count |
| done_o | output | 1 | One-cycle pulse when result_o is updated |
| ovf_o | output | 1 | A phase saturated during this conversion |

## Verification
A table of conversions covers:
- Positive, negative, zero and large-magnitude differences.
- Both subtraction methods for each of these, which shows whether the final +1 and the complement are right.
- Double-rate runs that place the comparator rise in the first half or the second half of a period. Only the half-cycle term tells these apart.

Directed runs cover the following:
- A phase that never ends, in both the reset and the signal phase, which separates the saturation value from an ordinary count.
- A change of ddr_i in the middle of a conversion, which shows whether the configuration is latched at the start.
- The clearing of the result and the overflow flag when a new conversion begins.

// File: rtl/dcds_pkg.sv
package dcds_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_COUNT, ST_FIN} dcds_state_e;
  typedef enum logic {PH_RST = 1'b0, PH_SIG = 1'b1} dcds_phase_e;
  typedef enum logic {SUB_DOWN = 1'b0, SUB_INV = 1'b1} dcds_sub_e;
endpackage

// File: rtl/dcds_cmp_sync.sv
module dcds_cmp_sync #(
  parameter int SYNC_N = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cmp_i,
  output logic stop_o,
  output logic late_o
);
  logic [SYNC_N-1:0] s_q;
  logic [SYNC_N-1:0] h_q;
  logic              hn_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) s_q <= '0;
    else         s_q <= {s_q[SYNC_N-2:0], cmp_i};

  // falling-edge sample gives the half-period position of the toggle
  always_ff @(negedge clk_i or negedge rst_ni)
    if (!rst_ni) hn_q <= 1'b0;
    else         hn_q <= cmp_i;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) h_q <= '0;
    else         h_q <= {h_q[SYNC_N-2:0], hn_q};

  assign stop_o = s_q[SYNC_N-1];
  // toggle after the falling edge: the half-rate chain lags by one cycle
  assign late_o = ~h_q[SYNC_N-1];
endmodule

// File: rtl/dcds_acc.sv
module dcds_acc #(
  parameter int CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             mclr_i,
  input  logic             inv_i,
  input  logic             en_i,
  input  logic             down_i,
  input  logic             ddr_i,
  input  logic             stop_i,
  input  logic             late_i,
  output logic [CNT_W-1:0] acc_o,
  output logic             sat_o
);
  localparam logic [CNT_W-1:0] LIMIT = {1'b0, {(CNT_W-1){1'b1}}};

  logic [CNT_W-1:0] acc_q, mag_q, room, raw, inc;

  always_comb begin
    room = LIMIT - mag_q;
    if (stop_i)     raw = CNT_W'(ddr_i & late_i);
    else if (ddr_i) raw = CNT_W'(2);
    else            raw = CNT_W'(1);
    inc = (raw > room) ? room : raw;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      mag_q <= '0;
    end else if (clr_i) begin
      acc_q <= '0;
      mag_q <= '0;
    end else if (mclr_i) begin
      mag_q <= '0;
      if (inv_i) acc_q <= ~acc_q;
    end else if (en_i) begin
      mag_q <= mag_q + inc;
      acc_q <= down_i ? acc_q - inc : acc_q + inc;
    end
  end

  assign acc_o = acc_q;
  assign sat_o = (mag_q == LIMIT);

  // R5
  sat_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && sat_o && !clr_i && !mclr_i) |=> $stable(acc_q));
endmodule

// File: rtl/dcds_ctrl.sv
module dcds_ctrl
  import dcds_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             phase_i,
  input  logic             mode_i,
  input  logic             ddr_i,
  input  logic             stop_i,
  input  logic             sat_i,
  input  logic [CNT_W-1:0] acc_i,
  output logic             clr_o,
  output logic             mclr_o,
  output logic             inv_o,
  output logic             en_o,
  output logic             down_o,
  output logic             ddr_o,
  output logic [CNT_W-1:0] result_o,
  output logic             done_o,
  output logic             ovf_o
);
  dcds_state_e      state_q;
  dcds_phase_e      ph_q;
  dcds_sub_e        mode_q;
  logic             ddr_q, ovf_q, done_q;
  logic [CNT_W-1:0] res_q;
  logic             rst_start, sig_start, phase_end;

  assign rst_start = start_i && (phase_i == PH_RST);
  assign sig_start = start_i && (phase_i == PH_SIG);
  assign phase_end = (state_q == ST_COUNT) && (stop_i || sat_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ph_q    <= PH_RST;
      mode_q  <= SUB_DOWN;
      ddr_q   <= 1'b0;
      ovf_q   <= 1'b0;
      done_q  <= 1'b0;
      res_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (rst_start) begin
        state_q <= ST_COUNT;
        ph_q    <= PH_RST;
        mode_q  <= dcds_sub_e'(mode_i);
        ddr_q   <= ddr_i;
        ovf_q   <= 1'b0;
        res_q   <= '0;
      end else if (sig_start) begin
        state_q <= ST_COUNT;
        ph_q    <= PH_SIG;
      end else begin
        case (state_q)
          ST_COUNT: if (phase_end) begin
            ovf_q   <= ovf_q | sat_i;
            state_q <= (ph_q == PH_SIG) ? ST_FIN : ST_IDLE;
          end
          ST_FIN: begin
            // invert method owes +1 to complete the negation
            res_q   <= acc_i + CNT_W'(mode_q == SUB_INV);
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end
          default: ;
        endcase
      end
    end
  end

  assign clr_o    = rst_start;
  assign mclr_o   = sig_start;
  assign inv_o    = sig_start && (mode_q == SUB_INV);
  assign en_o     = (state_q == ST_COUNT) && !start_i;
  assign down_o   = (ph_q == PH_RST) && (mode_q == SUB_DOWN);
  assign ddr_o    = ddr_q;
  assign result_o = res_q;
  assign done_o   = done_q;
  assign ovf_o    = ovf_q;

  // R6
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  // R6
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_FIN && !rst_start) |=> $stable(res_q));
  // R5
  ovf_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_q && !rst_start) |=> ovf_q);
  // R7
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rst_start |=> ($stable(ddr_q) && $stable(mode_q)));
  // R4
  stop_leave_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_COUNT && stop_i && !start_i) |=> (state_q != ST_COUNT));
endmodule

// File: rtl/col_dcds_counter.sv
module col_dcds_counter #(
  parameter int CNT_W  = 12,
  parameter int SYNC_N = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmp_i,
  input  logic             start_i,
  input  logic             phase_i,
  input  logic             mode_i,
  input  logic             ddr_i,
  output logic [CNT_W-1:0] result_o,
  output logic             done_o,
  output logic             ovf_o
);
  logic             stop, late, sat, clr, mclr, inv, en, down, ddr;
  logic [CNT_W-1:0] acc;

  dcds_cmp_sync #(.SYNC_N(SYNC_N)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .cmp_i(cmp_i),
    .stop_o(stop), .late_o(late)
  );

  dcds_acc #(.CNT_W(CNT_W)) u_acc (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr), .mclr_i(mclr), .inv_i(inv),
    .en_i(en), .down_i(down), .ddr_i(ddr), .stop_i(stop), .late_i(late),
    .acc_o(acc), .sat_o(sat)
  );

  dcds_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .phase_i(phase_i),
    .mode_i(mode_i), .ddr_i(ddr_i), .stop_i(stop), .sat_i(sat), .acc_i(acc),
    .clr_o(clr), .mclr_o(mclr), .inv_o(inv), .en_o(en), .down_o(down),
    .ddr_o(ddr), .result_o(result_o), .done_o(done_o), .ovf_o(ovf_o)
  );
endmodule

// File: tb/tb_col_dcds_counter.sv
module tb_col_dcds_counter;
  localparam int CLK_T = 10;
  localparam int CNT_W = 12;
  localparam int LIMIT = (1 << (CNT_W - 1)) - 1;
  localparam int NV    = 8;
  // {mode, ddr, rst_late, sig_late, rst_n[11:0], sig_n[11:0]}
  localparam logic [27:0] VECS [NV] = '{
    {1'b0, 1'b0, 1'b0, 1'b0, 12'd10,  12'd50},
    {1'b1, 1'b0, 1'b0, 1'b0, 12'd10,  12'd50},
    {1'b0, 1'b0, 1'b1, 1'b0, 12'd60,  12'd20},
    {1'b1, 1'b0, 1'b0, 1'b1, 12'd60,  12'd20},
    {1'b0, 1'b1, 1'b0, 1'b1, 12'd10,  12'd30},
    {1'b1, 1'b1, 1'b1, 1'b0, 12'd10,  12'd30},
    {1'b1, 1'b1, 1'b0, 1'b0, 12'd5,   12'd5},
    {1'b0, 1'b0, 1'b0, 1'b0, 12'd300, 12'd1}
  };

  logic clk = 1'b0, rst_n = 1'b0, cmp = 1'b0, start = 1'b0;
  logic phase = 1'b0, mode = 1'b0, ddr = 1'b0;
  logic [CNT_W-1:0] result;
  logic done, ovf;
  int checks = 0, failures = 0, done_cnt = 0;

  always #(CLK_T/2) clk = ~clk;

  col_dcds_counter #(.CNT_W(CNT_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .cmp_i(cmp), .start_i(start), .phase_i(phase),
    .mode_i(mode), .ddr_i(ddr), .result_o(result), .done_o(done), .ovf_o(ovf)
  );

  always @(negedge clk) if (done) done_cnt++;

  initial begin
    repeat (200000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int phase_cnt(input int n, input bit late, input bit dr);
    int c;
    if (n < 0) return LIMIT;
    c = dr ? 2 * (n + 2) + int'(late) : n + 2;
    return (c > LIMIT) ? LIMIT : c;
  endfunction

  // n<0: comparator never rises
  task automatic run_phase(input bit ph, input int n, input bit late, input bit flip);
    @(negedge clk); start = 1'b1; phase = ph;
    @(posedge clk);
    #(CLK_T/2); start = 1'b0;
    if (flip) ddr = ~ddr;
    if (n < 0) repeat (2100) @(posedge clk);
    else begin
      #(n * CLK_T + (late ? 7 : 2) - CLK_T/2);
      cmp = 1'b1;
      repeat (6) @(posedge clk);
    end
    @(negedge clk); cmp = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic run_conv(input bit m, input bit d, input int rn, input bit rl,
                          input int sn, input bit sl, input bit flip);
    @(negedge clk); mode = m; ddr = d;
    run_phase(1'b0, rn, rl, flip);
    run_phase(1'b1, sn, sl, 1'b0);
  endtask

  initial begin
    int exp, d0;
    repeat (3) @(negedge clk);
    // R8 reset state
    check("R8 result", int'(result), 0);
    check("R8 done", int'(done), 0);
    check("R8 ovf", int'(ovf), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      bit m, d, rl, sl;
      int rn, sn;
      string tag;
      {m, d, rl, sl} = VECS[i][27:24];
      rn = int'(VECS[i][23:12]);
      sn = int'(VECS[i][11:0]);
      d0 = done_cnt;
      run_conv(m, d, rn, rl, sn, sl, 1'b0);
      exp = phase_cnt(sn, sl, d) - phase_cnt(rn, rl, d);
      tag = d ? "R3 ddr diff" : (m ? "R2 invert diff" : "R1 down diff");
      check(tag, int'($signed(result)), exp);
      check("R4 R9 no ovf", int'(ovf), 0);
      check("R6 one done", done_cnt - d0, 1);
    end

    // R3 R4: SDR ignores half-cycle position
    run_conv(1'b0, 1'b0, 40, 1'b0, 40, 1'b1, 1'b0);
    check("R3 R4 sdr half ignored", int'($signed(result)), 0);

    // R6 result held while idle
    exp = int'($signed(result));
    repeat (20) @(negedge clk);
    check("R6 hold", int'($signed(result)), exp);

    // R5 reset phase saturates, down-count
    run_conv(1'b0, 1'b0, -1, 1'b0, 100, 1'b0, 1'b0);
    check("R5 rst sat diff", int'($signed(result)), 102 - LIMIT);
    check("R5 rst sat ovf", int'(ovf), 1);

    // R5 signal phase saturates, invert, double rate
    d0 = done_cnt;
    run_conv(1'b1, 1'b1, 20, 1'b0, -1, 1'b0, 1'b0);
    check("R5 sig sat diff", int'($signed(result)), LIMIT - 44);
    check("R5 sig sat ovf", int'(ovf), 1);
    check("R6 one done after sat", done_cnt - d0, 1);

    // R6 reset-phase start clears result and ovf
    @(negedge clk); start = 1'b1; phase = 1'b0; mode = 1'b0; ddr = 1'b0;
    @(negedge clk); start = 1'b0;
    check("R6 clear result", int'(result), 0);
    check("R6 clear ovf", int'(ovf), 0);
    cmp = 1'b1;
    repeat (6) @(negedge clk);
    cmp = 1'b0;
    repeat (4) @(negedge clk);

    // R7 ddr change after start is ignored (latched 0)
    run_conv(1'b1, 1'b0, 15, 1'b0, 45, 1'b1, 1'b1);
    check("R7 ddr latched", int'($signed(result)), 30);
    ddr = 1'b0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule